// File: doc/BRIEF.md
# Link-Training Coefficient Update Responder

This block answers a link partner's transmit-equalizer requests during backplane link training. It stores three settings: a post-cursor ratio, a main level and a pre-cursor ratio. Each time a request word is presented with its valid flag, the block may step one or more taps up or down, load the preset or initialize values, or clear tap status. The answer goes back as a 6-bit status word. The block pulses a one-clock strobe whenever the stored settings change, so the transmitter can pick up the new values.

Every step the partner asks for is first tried on a copy of the settings. The copy is screened against a set of arithmetic legality rules. A step that would leave the legal region, or that is already at the tap's end point, is refused. A refused step reports minimum or maximum, depending on which way it was asked to move. Once the partner signals that its receiver is ready, the block stops changing its settings.

Top module: `kr_coef_responder`

## Requirements
- R1: After reset the post ratio is 13, the main level is 32, the pre ratio is 2, the status word is 0 and the strobe is low.
- R2: Fields are laid out the same way in the request word and the status word. The pre tap is bits [1:0], the main tap is bits [3:2] and the post tap is bits [5:4]. Request bit 6 asks for initialize and request bit 7 asks for preset. Request codes are 0 hold, 1 increment and 2 decrement. Status codes are 0 not updated, 1 updated, 2 minimum and 3 maximum. Only a cycle with reqValid high is evaluated, and its results appear one clock later. With reqValid low, the outputs do not change.
- R3: A tap whose request code is hold has its status cleared to not updated. This does not happen when bit 6 or bit 7 is set in the same request.
- R4: Preset loads post 0, main 48 and pre 0, and reports maximum on all three taps. It is acted on only when all three statuses are not updated.
- R5: Initialize loads post 13, main 32 and pre 2, and reports updated on all three taps. It is acted on only when all three statuses are not updated. If both bits are set, initialize wins.
- R6: Incrementing the post or pre tap lowers its stored ratio by 1. Incrementing the main tap raises the main level by 1. Decrement moves each of them the other way.
- R7: A step on a tap is applied only while that tap's status is not updated. Otherwise the request has no effect.
- R8: An increment is refused at post 0, main 48 or pre 0, and reports maximum. A decrement is refused at post 16, main 0 or pre 8, and reports minimum. A refused step leaves the setting unchanged.
- R9: A proposed setting is refused if any of these holds: pre > post; main < 26; post > 16; pre > 8; the sum of the three exceeds 48; or 4 × sum ≥ 17 × (main − post − pre). A refused step reports maximum for an increment and minimum for a decrement, and the setting is unchanged. A step that is accepted reports updated.
- R10: An evaluated request made while partnerRdy is high clears all three statuses and changes no setting.
- R11: settingsUpdate is high for exactly the one cycle after an evaluation that changed or reloaded the settings, and is low at all other times.
- R12: Request code 3 on a tap is treated as hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Evaluate reqWord this cycle |
| reqWord | input | 8 | Partner request: tap codes, initialize and preset bits |
| partnerRdy | input | 1 | Partner receiver ready |
| statusWord | output | 6 | Registered per-tap status reply |
| postRatio | output | 5 | Stored post-cursor ratio |
| mainLevel | output | 6 | Stored main level |
| preRatio | output | 4 | Stored pre-cursor ratio |
| settingsUpdate | output | 1 | One-cycle pulse when settings change |

## Verification
Rejection by the legality rules is the hardest case to reach, because it only occurs a few steps away from the defaults and only when the tap's status has been cleared first. The stimulus walks the settings with alternating step and hold requests until the sum reaches 48. It then asks for one more step, which must be refused, and does the same from the preset corner, where a pre decrement breaks the pre ≤ post rule. The stimulus also checks that preset and initialize are ignored while any status is still set. Separately, it checks that a pending status is not cleared when a request carries the preset or initialize bit.

// File: rtl/kr_coef_pkg.sv
package kr_coef_pkg;
  localparam int NUM_TAPS = 3;
  localparam int TAP_PRE  = 0;
  localparam int TAP_MAIN = 1;
  localparam int TAP_POST = 2;

  localparam logic [1:0] REQ_HOLD = 2'd0;
  localparam logic [1:0] REQ_INC  = 2'd1;
  localparam logic [1:0] REQ_DEC  = 2'd2;

  localparam logic [1:0] ST_NOTUPD = 2'd0;
  localparam logic [1:0] ST_UPD    = 2'd1;
  localparam logic [1:0] ST_MIN    = 2'd2;
  localparam logic [1:0] ST_MAX    = 2'd3;

  localparam int INIT_BIT   = 6;
  localparam int PRESET_BIT = 7;

  // legality rule constants
  localparam int SUM_CAP    = 48;
  localparam int SUM_MUL    = 4;
  localparam int MARGIN_MUL = 17;
  localparam int MAIN_FLOOR = 26;
  localparam int PRE_CAP    = 8;
  localparam int POST_CAP   = 16;

  typedef struct packed {
    logic                      evalEn;
    logic                      doPreset;
    logic                      doInit;
    logic [NUM_TAPS-1:0][1:0]  stepCode;
  } coefCtl_t;

  function automatic logic settingLegal(int post, int main, int pre);
    int sum;
    sum = post + main + pre;
    settingLegal = 1'b1;
    if (sum > SUM_CAP) settingLegal = 1'b0;
    if (SUM_MUL * sum >= MARGIN_MUL * (main - post - pre)) settingLegal = 1'b0;
    if (pre > post) settingLegal = 1'b0;
    if (pre > PRE_CAP) settingLegal = 1'b0;
    if (main < MAIN_FLOOR) settingLegal = 1'b0;
    if (post > POST_CAP) settingLegal = 1'b0;
  endfunction
endpackage

// File: rtl/kr_coef_ctl.sv
module kr_coef_ctl
  import kr_coef_pkg::*;
#(
  parameter int ReqW = 8,
  parameter int StW  = 2 * NUM_TAPS
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [ReqW-1:0]  reqWord,
  input  logic             partnerRdy,
  input  logic [NUM_TAPS-1:0] tapOk,
  output coefCtl_t         ctl,
  output logic [StW-1:0]   statusWord
);
  localparam logic [StW-1:0] ALL_UPD = {NUM_TAPS{ST_UPD}};
  localparam logic [StW-1:0] ALL_MAX = {NUM_TAPS{ST_MAX}};

  logic [StW-1:0] statusQ, baseSt, nextSt;
  logic           piReq;

  assign piReq = reqWord[INIT_BIT] | reqWord[PRESET_BIT];

  // Stage 1: hold clearing, preset/initialize gating and step gating
  always_comb begin
    ctl    = '0;
    baseSt = statusQ;
    for (int t = 0; t < NUM_TAPS; t++) begin
      if (!piReq && (reqWord[2*t +: 2] == REQ_HOLD || reqWord[2*t +: 2] == 2'd3))
        baseSt[2*t +: 2] = ST_NOTUPD;
    end
    if (reqValid && !partnerRdy) begin
      ctl.evalEn = 1'b1;
      if (piReq && statusQ == '0) begin
        ctl.doPreset = reqWord[PRESET_BIT];
        ctl.doInit   = reqWord[INIT_BIT];
        baseSt       = reqWord[INIT_BIT] ? ALL_UPD : ALL_MAX;
      end
      for (int t = 0; t < NUM_TAPS; t++) begin
        if ((reqWord[2*t +: 2] == REQ_INC || reqWord[2*t +: 2] == REQ_DEC) &&
            baseSt[2*t +: 2] == ST_NOTUPD)
          ctl.stepCode[t] = reqWord[2*t +: 2];
      end
    end
  end

  // Stage 2: fold in the datapath's verdict per tap
  always_comb begin
    nextSt = statusQ;
    if (reqValid) begin
      if (partnerRdy) begin
        nextSt = '0;
      end else begin
        nextSt = baseSt;
        for (int t = 0; t < NUM_TAPS; t++) begin
          if (ctl.stepCode[t] != REQ_HOLD)
            nextSt[2*t +: 2] = tapOk[t] ? ST_UPD :
                               (ctl.stepCode[t] == REQ_INC ? ST_MAX : ST_MIN);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= nextSt;
  end

  assign statusWord = statusQ;
endmodule

// File: rtl/kr_coef_path.sv
module kr_coef_path
  import kr_coef_pkg::*;
#(
  parameter int PostW      = 5,
  parameter int MainW      = 6,
  parameter int PreW       = 4,
  parameter int PostDef    = 13,
  parameter int MainDef    = 32,
  parameter int PreDef     = 2,
  parameter int PostIncLim = 0,
  parameter int MainIncLim = 48,
  parameter int PreIncLim  = 0,
  parameter int PostDecLim = 16,
  parameter int MainDecLim = 0,
  parameter int PreDecLim  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  coefCtl_t         ctl,
  output logic [NUM_TAPS-1:0] tapOk,
  output logic [PostW-1:0] postRatio,
  output logic [MainW-1:0] mainLevel,
  output logic [PreW-1:0]  preRatio,
  output logic             settingsUpdate
);
  logic [PostW-1:0] postQ;
  logic [MainW-1:0] mainQ;
  logic [PreW-1:0]  preQ;
  logic             updQ, load;
  int               pNew, mNew, rNew;

  always_comb begin
    int tp, tm, tr;
    logic atLim;
    pNew  = int'(postQ);
    mNew  = int'(mainQ);
    rNew  = int'(preQ);
    tapOk = '0;
    if (ctl.doInit) begin
      pNew = PostDef; mNew = MainDef; rNew = PreDef;
    end else if (ctl.doPreset) begin
      pNew = PostIncLim; mNew = MainIncLim; rNew = PreIncLim;
    end
    // taps are tried post, then main, then pre; each sees the earlier result
    for (int k = NUM_TAPS - 1; k >= 0; k--) begin
      tp = pNew; tm = mNew; tr = rNew; atLim = 1'b0;
      if (ctl.stepCode[k] != REQ_HOLD) begin
        case (k)
          TAP_POST: begin
            if (ctl.stepCode[k] == REQ_INC) begin
              if (pNew == PostIncLim) atLim = 1'b1; else tp = pNew - 1;
            end else begin
              if (pNew == PostDecLim) atLim = 1'b1; else tp = pNew + 1;
            end
          end
          TAP_MAIN: begin
            if (ctl.stepCode[k] == REQ_INC) begin
              if (mNew == MainIncLim) atLim = 1'b1; else tm = mNew + 1;
            end else begin
              if (mNew == MainDecLim) atLim = 1'b1; else tm = mNew - 1;
            end
          end
          default: begin
            if (ctl.stepCode[k] == REQ_INC) begin
              if (rNew == PreIncLim) atLim = 1'b1; else tr = rNew - 1;
            end else begin
              if (rNew == PreDecLim) atLim = 1'b1; else tr = rNew + 1;
            end
          end
        endcase
        if (!atLim && settingLegal(tp, tm, tr)) begin
          pNew = tp; mNew = tm; rNew = tr;
          tapOk[k] = 1'b1;
        end
      end
    end
  end

  assign load = ctl.evalEn && (ctl.doPreset || ctl.doInit || tapOk != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      postQ <= PostW'(PostDef);
      mainQ <= MainW'(MainDef);
      preQ  <= PreW'(PreDef);
      updQ  <= 1'b0;
    end else begin
      updQ <= load;
      if (load) begin
        postQ <= PostW'(pNew);
        mainQ <= MainW'(mNew);
        preQ  <= PreW'(rNew);
      end
    end
  end

  assign postRatio      = postQ;
  assign mainLevel      = mainQ;
  assign preRatio       = preQ;
  assign settingsUpdate = updQ;
endmodule

// File: rtl/kr_coef_responder.sv
module kr_coef_responder
  import kr_coef_pkg::*;
#(
  parameter int PostW = 5,
  parameter int MainW = 6,
  parameter int PreW  = 4,
  parameter int ReqW  = 8,
  localparam int StW  = 2 * NUM_TAPS
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [ReqW-1:0]  reqWord,
  input  logic             partnerRdy,
  output logic [StW-1:0]   statusWord,
  output logic [PostW-1:0] postRatio,
  output logic [MainW-1:0] mainLevel,
  output logic [PreW-1:0]  preRatio,
  output logic             settingsUpdate
);
  coefCtl_t            ctl;
  logic [NUM_TAPS-1:0] tapOk;

  kr_coef_ctl #(.ReqW(ReqW), .StW(StW)) uCtl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWord(reqWord),
    .partnerRdy(partnerRdy), .tapOk(tapOk), .ctl(ctl), .statusWord(statusWord)
  );

  kr_coef_path #(.PostW(PostW), .MainW(MainW), .PreW(PreW)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .tapOk(tapOk),
    .postRatio(postRatio), .mainLevel(mainLevel), .preRatio(preRatio),
    .settingsUpdate(settingsUpdate)
  );
endmodule

// File: rtl/kr_coef_chk.sv
module kr_coef_chk
  import kr_coef_pkg::*;
#(
  parameter int PostW = 5,
  parameter int MainW = 6,
  parameter int PreW  = 4,
  parameter int ReqW  = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [ReqW-1:0]  reqWord,
  input logic             partnerRdy,
  input logic [5:0]       statusWord,
  input logic [PostW-1:0] postRatio,
  input logic [MainW-1:0] mainLevel,
  input logic [PreW-1:0]  preRatio,
  input logic             settingsUpdate
);
  p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> ($stable(statusWord) && $stable(postRatio) &&
                   $stable(mainLevel) && $stable(preRatio) && !settingsUpdate));

  p_ready_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && partnerRdy) |=> (statusWord == '0 && !settingsUpdate));

  p_strobe_needs_eval_r11: assert property (@(posedge clk) disable iff (!rstN)
    settingsUpdate |-> $past(reqValid));

  p_change_strobes_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(postRatio) || !$stable(mainLevel) || !$stable(preRatio)) |-> settingsUpdate);

  p_legal_setting_r9: assert property (@(posedge clk) disable iff (!rstN)
    settingLegal(int'(postRatio), int'(mainLevel), int'(preRatio)));
endmodule

bind kr_coef_responder kr_coef_chk #(.PostW(PostW), .MainW(MainW), .PreW(PreW), .ReqW(ReqW)) uChk (.*);

// File: tb/sim_kr_coef_responder.sv
`timescale 1ns/1ps
module sim_kr_coef_responder;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [7:0] reqWord = '0;
  logic       partnerRdy = 1'b0;
  logic [5:0] statusWord;
  logic [4:0] postRatio;
  logic [5:0] mainLevel;
  logic [3:0] preRatio;
  logic       settingsUpdate;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  kr_coef_responder u0 (.*);

  task automatic chk(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  // request word: post [5:4], main [3:2], pre [1:0], init bit 6, preset bit 7
  function automatic logic [7:0] mk(int post, int main, int pre, bit ini, bit pre_set);
    return {pre_set, ini, post[1:0], main[1:0], pre[1:0]};
  endfunction

  // present one request; return at the next falling edge with results visible
  task automatic send(logic [7:0] w, bit rdy);
    @(negedge clk);
    reqWord = w; partnerRdy = rdy; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0; partnerRdy = 1'b0;
  endtask

  task automatic expect_set(string req, int p, int m, int r, int st, int upd);
    chk({req, " post"}, postRatio, p);
    chk({req, " main"}, mainLevel, m);
    chk({req, " pre"}, preRatio, r);
    chk({req, " status"}, statusWord, st);
    chk({req, " strobe"}, settingsUpdate, upd);
  endtask

  task automatic t_reset();
    expect_set("R1", 13, 32, 2, 0, 0);
  endtask

  task automatic t_no_eval();
    @(negedge clk); reqWord = mk(1, 1, 1, 0, 0);
    @(negedge clk); @(negedge clk);
    expect_set("R2 idle", 13, 32, 2, 0, 0);
  endtask

  task automatic t_steps();
    send(mk(1, 0, 0, 0, 0), 0);
    expect_set("R6 post inc", 12, 32, 2, 'h10, 1);
    @(negedge clk);
    chk("R11 strobe one cycle", settingsUpdate, 0);
    send(mk(1, 0, 0, 0, 0), 0);
    expect_set("R7 gated", 12, 32, 2, 'h10, 0);
    send(mk(0, 0, 0, 0, 0), 0);
    expect_set("R3 hold clears", 12, 32, 2, 0, 0);
    send(mk(0, 1, 0, 0, 0), 0);
    expect_set("R6 main inc", 12, 33, 2, 'h04, 1);
    send(mk(0, 0, 0, 0, 0), 0);
    send(mk(0, 0, 2, 0, 0), 0);
    expect_set("R6 pre dec", 12, 33, 3, 'h01, 1);
    send(mk(0, 0, 0, 0, 0), 0);
  endtask

  task automatic t_reject_sum();
    send(mk(0, 1, 0, 0, 0), 0);
    expect_set("R9 sum over cap", 12, 33, 3, 'h0C, 0);
    send(mk(0, 0, 0, 0, 0), 0);
  endtask

  task automatic t_preset();
    send(mk(0, 0, 0, 0, 1), 0);
    expect_set("R4 preset", 0, 48, 0, 'h3F, 1);
    send(mk(0, 0, 0, 1, 0), 0);
    expect_set("R5 init gated R3 kept", 0, 48, 0, 'h3F, 0);
    send(mk(0, 0, 0, 0, 0), 0);
    send(mk(1, 1, 0, 0, 0), 0);
    expect_set("R8 inc at limit", 0, 48, 0, 'h3C, 0);
    send(mk(0, 0, 0, 0, 0), 0);
    send(mk(0, 0, 2, 0, 0), 0);
    expect_set("R9 pre over post", 0, 48, 0, 'h02, 0);
    send(mk(0, 0, 0, 0, 0), 0);
  endtask

  task automatic t_init();
    send(mk(0, 0, 0, 1, 0), 0);
    expect_set("R5 init", 13, 32, 2, 'h15, 1);
    send(mk(0, 0, 0, 0, 0), 0);
    send(mk(2, 0, 0, 0, 0), 0);
    expect_set("R6 post dec", 14, 32, 2, 'h10, 1);
    send(mk(0, 0, 0, 0, 0), 0);
    send(mk(2, 0, 0, 0, 0), 0);
    expect_set("R9 dec rejected", 14, 32, 2, 'h20, 0);
    send(mk(0, 0, 0, 0, 0), 0);
    send(mk(0, 0, 0, 1, 1), 0);
    expect_set("R5 init wins", 13, 32, 2, 'h15, 1);
    send(mk(0, 0, 0, 0, 0), 0);
  endtask

  task automatic t_code3();
    send(mk(0, 1, 0, 0, 0), 0);
    expect_set("R12 setup", 13, 33, 2, 'h04, 1);
    send(mk(0, 3, 0, 0, 0), 0);
    expect_set("R12 code3 hold", 13, 33, 2, 0, 0);
  endtask

  task automatic t_ready();
    send(mk(0, 1, 0, 0, 0), 0);
    expect_set("R10 setup", 13, 33, 2, 'h0C, 0);
    send(mk(1, 0, 0, 0, 1), 1);
    expect_set("R10 ready", 13, 33, 2, 0, 0);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_eval();
    t_steps();
    t_reject_sum();
    t_preset();
    t_init();
    t_code3();
    t_ready();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule